// File: doc/BRIEF.md
# Capacitive Divider Measurement Sequencer

This block steps an ADC through a capacitive voltage divider measurement. One measurement is made of three phases in fixed order: pre-charge, acquisition and conversion. During pre-charge the sensed channel and the internal hold capacitor are each tied to a rail whose level comes from a control bit. Acquisition then lets the charges share. Conversion raises a request to the ADC and waits for its done input. Phase lengths for pre-charge and acquisition are programmable in clock cycles.

A double-sample mode runs a second measurement straight after the first, without clearing the busy flag. An invert option flips every driven polarity (channel, hold capacitor, guard and pin override) for that second measurement only. This supports differential sensing. The stored control bits never change. The block also gives the analog output pin its connection controls: a pre-charge override, a pass-gate link and a low-impedance link to the ADC bus. Software writes control fields through a small register port and starts or aborts a measurement through a run bit.

Top module: `cvd_seq`

## Requirements
- R1: After reset every register reads 0, `busy` is 0, and all drive, override, pin-connection and conversion outputs are 0.
- R2: Register 0 is the control byte: bit0 double-sample, bit1 invert, bit2 unused (always reads 0), bit3 pin override, bit4 pass-gate link, bit5 low-impedance link, bit6 hold polarity, bit7 channel polarity. Register 1 is the pre-charge count and register 2 the acquisition count, both read back as written. Register 3 has bit0 run/busy and bit1 guard polarity.
- R3: Writing 1 to run bit 0 while idle starts pre-charge in the next cycle. Pre-charge lasts exactly the pre-charge count in cycles. During it, `ext_drv_en` and `hold_drv_en` are 1, `ext_drv_lvl` equals the channel polarity bit and `hold_drv_lvl` equals the hold polarity bit. Outside pre-charge all four outputs are 0.
- R4: Acquisition follows pre-charge and lasts exactly the acquisition count in cycles. A count of 0 skips its phase. `adc_conv` is 1 throughout conversion until `adc_done` is seen.
- R5: In single mode (double-sample bit 0), the cycle after `adc_done` is seen during conversion shows a one-cycle `samp_done` with `samp_idx` 0, and `busy` is 0 in that cycle. The invert bit has no effect in this mode.
- R6: In double-sample mode, a second pre-charge/acquisition/conversion sequence starts in the cycle after the first `adc_done`, and `busy` stays 1. `samp_done` pulses with `samp_idx` 0 after the first conversion and with `samp_idx` 1 after the second. `busy` falls with the second pulse.
- R7: With both double-sample and invert set, `ext_drv_lvl`, `hold_drv_lvl`, `guard_lvl` and `pin_ovr_lvl` are inverted during the second measurement only. Register 0 still reads its written value.
- R8: With the override bit set, `pin_ovr_en` is 1 only during pre-charge, and `pin_ovr_lvl` then equals the hold polarity (after any R7 inversion). Otherwise both are 0.
- R9: `pin_pass_en` and `pin_lowz_en` follow control bits 4 and 5 at all times. With both bits clear the pin is disconnected.
- R10: Writing 0 to run bit 0 during any phase returns the block to idle in the next cycle. `busy`, the drives and `adc_conv` are then all 0.
- R11: `guard_lvl` equals the guard polarity bit whenever no R7 inversion is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| adc_done | input | 1 | Conversion complete from the ADC |
| adc_conv | output | 1 | Conversion request to the ADC |
| busy | output | 1 | Measurement in progress |
| ext_drv_en | output | 1 | Tie sensed channel to a rail |
| ext_drv_lvl | output | 1 | Rail for sensed channel (1 = high) |
| hold_drv_en | output | 1 | Tie hold capacitor to a rail |
| hold_drv_lvl | output | 1 | Rail for hold capacitor (1 = high) |
| guard_lvl | output | 1 | Guard ring drive level |
| pin_ovr_en | output | 1 | Force analog output pin |
| pin_ovr_lvl | output | 1 | Forced level of analog output pin |
| pin_pass_en | output | 1 | Pass-gate link of pin to ADC bus |
| pin_lowz_en | output | 1 | Low-impedance link of pin to ADC bus |
| samp_done | output | 1 | One-cycle end-of-conversion pulse |
| samp_idx | output | 1 | Index of the finished conversion |

## Verification
A run-bit write takes effect at the clock edge where it is sampled. The bench therefore checks the first pre-charge cycle at the falling edge right after that write, then counts falling edges: N cycles of pre-charge, M cycles of acquisition, then `adc_conv`. `adc_done` is driven at a falling edge, and the bench expects `samp_done`, the updated `busy` and any second-sample inversion at the next falling edge. Abort and pin-link effects are likewise due one edge after their write. Register reads are combinational and are checked in the same half cycle.

// File: rtl/cvd_pkg.sv
package cvd_pkg;
  localparam int REG_W = 8;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_PRE  = 2'd1;
  localparam logic [1:0] A_ACQ  = 2'd2;
  localparam logic [1:0] A_RUN  = 2'd3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_ACQ  = 2'd2,
    PH_CONV = 2'd3
  } phase_e;

  typedef struct packed {
    logic ext_pol;
    logic int_pol;
    logic lowz_en;
    logic pass_en;
    logic ovr_en;
    logic inv_en;
    logic dbl_en;
  } ctrl_t;
endpackage

// File: rtl/cvd_rst_sync.sv
module cvd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/cvd_regs.sv
module cvd_regs
  import cvd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [1:0]         rd_addr,
  input  logic               busy_i,
  output ctrl_t              ctrl_o,
  output logic [CNT_W-1:0]   pre_cnt_o,
  output logic [CNT_W-1:0]   acq_cnt_o,
  output logic               guard_o,
  output logic               start_o,
  output logic               abort_o,
  output logic [REG_W-1:0]   rd_data_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] pre_q, pre_d, acq_q, acq_d;
  logic             guard_q, guard_d;
  logic             ctrl_we, pre_we, acq_we, run_we;

  // write decode and next values
  always_comb begin
    ctrl_we = wr_en && (wr_addr == A_CTRL);
    pre_we  = wr_en && (wr_addr == A_PRE);
    acq_we  = wr_en && (wr_addr == A_ACQ);
    run_we  = wr_en && (wr_addr == A_RUN);
    ctrl_d.ext_pol = wr_data[7];
    ctrl_d.int_pol = wr_data[6];
    ctrl_d.lowz_en = wr_data[5];
    ctrl_d.pass_en = wr_data[4];
    ctrl_d.ovr_en  = wr_data[3];
    ctrl_d.inv_en  = wr_data[1];
    ctrl_d.dbl_en  = wr_data[0];
    pre_d   = wr_data[CNT_W-1:0];
    acq_d   = wr_data[CNT_W-1:0];
    guard_d = wr_data[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      pre_q   <= '0;
      acq_q   <= '0;
      guard_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q  <= ctrl_d;
      if (pre_we)  pre_q   <= pre_d;
      if (acq_we)  acq_q   <= acq_d;
      if (run_we)  guard_q <= guard_d;
    end
  end

  assign start_o = run_we && wr_data[0];
  assign abort_o = run_we && !wr_data[0];

  // readback; bit 2 of the control byte is not stored
  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr)
      A_CTRL: rd_data_o = {ctrl_q.ext_pol, ctrl_q.int_pol, ctrl_q.lowz_en,
                           ctrl_q.pass_en, ctrl_q.ovr_en, 1'b0,
                           ctrl_q.inv_en, ctrl_q.dbl_en};
      A_PRE:  rd_data_o = REG_W'(pre_q);
      A_ACQ:  rd_data_o = REG_W'(acq_q);
      A_RUN:  rd_data_o = {{(REG_W-2){1'b0}}, guard_q, busy_i};
      default: rd_data_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign pre_cnt_o = pre_q;
  assign acq_cnt_o = acq_q;
  assign guard_o   = guard_q;
endmodule

// File: rtl/cvd_timer.sv
module cvd_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cvd_fsm.sv
module cvd_fsm
  import cvd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] pre_cnt_i,
  input  logic [CNT_W-1:0] acq_cnt_i,
  input  logic             dbl_en_i,
  input  logic             adc_done_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output phase_e           phase_o,
  output logic             idx_o,
  output logic             done_o,
  output logic             done_idx_o
);
  phase_e           st_q, st_d;
  logic             idx_q, idx_d;
  logic             done_q, done_d;
  logic             didx_q, didx_d;
  phase_e           entry_ph;
  logic             entry_ld;
  logic [CNT_W-1:0] entry_val;

  // first phase of a measurement, skipping zero-length phases
  always_comb begin
    entry_ph  = PH_CONV;
    entry_ld  = 1'b0;
    entry_val = '0;
    if (pre_cnt_i != '0) begin
      entry_ph  = PH_PRE;
      entry_ld  = 1'b1;
      entry_val = pre_cnt_i - 1'b1;
    end else if (acq_cnt_i != '0) begin
      entry_ph  = PH_ACQ;
      entry_ld  = 1'b1;
      entry_val = acq_cnt_i - 1'b1;
    end
  end

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    done_d     = 1'b0;
    didx_d     = didx_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (st_q)
      PH_IDLE: begin
        if (start_i) begin
          st_d       = entry_ph;
          idx_d      = 1'b0;
          tmr_load_o = entry_ld;
          tmr_val_o  = entry_val;
        end
      end
      PH_PRE: begin
        if (tmr_zero_i) begin
          if (acq_cnt_i != '0) begin
            st_d       = PH_ACQ;
            tmr_load_o = 1'b1;
            tmr_val_o  = acq_cnt_i - 1'b1;
          end else begin
            st_d = PH_CONV;
          end
        end
      end
      PH_ACQ: begin
        if (tmr_zero_i) st_d = PH_CONV;
      end
      PH_CONV: begin
        if (adc_done_i) begin
          done_d = 1'b1;
          didx_d = idx_q;
          if (dbl_en_i && !idx_q) begin
            st_d       = entry_ph;
            idx_d      = 1'b1;
            tmr_load_o = entry_ld;
            tmr_val_o  = entry_val;
          end else begin
            st_d  = PH_IDLE;
            idx_d = 1'b0;
          end
        end
      end
      default: st_d = PH_IDLE;
    endcase
    // software abort wins over every phase
    if (abort_i && (st_q != PH_IDLE)) begin
      st_d       = PH_IDLE;
      idx_d      = 1'b0;
      done_d     = 1'b0;
      tmr_load_o = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      idx_q  <= 1'b0;
      done_q <= 1'b0;
      didx_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      if (done_d) didx_q <= didx_d;
    end
  end

  assign phase_o    = st_q;
  assign idx_o      = idx_q;
  assign done_o     = done_q;
  assign done_idx_o = didx_q;
endmodule

// File: rtl/cvd_seq.sv
module cvd_seq
  import cvd_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             adc_done,
  output logic             adc_conv,
  output logic             busy,
  output logic             ext_drv_en,
  output logic             ext_drv_lvl,
  output logic             hold_drv_en,
  output logic             hold_drv_lvl,
  output logic             guard_lvl,
  output logic             pin_ovr_en,
  output logic             pin_ovr_lvl,
  output logic             pin_pass_en,
  output logic             pin_lowz_en,
  output logic             samp_done,
  output logic             samp_idx
);
  localparam int CW = (CNT_W > REG_W) ? REG_W : CNT_W;

  logic             rst_n_s;
  ctrl_t            ctrl;
  logic [CW-1:0]    pre_cnt, acq_cnt;
  logic             guard_pol, start_req, abort_req;
  logic             tmr_load, tmr_zero;
  logic [CW-1:0]    tmr_val;
  phase_e           phase;
  logic             second, dbl_mode, flip, in_pre;

  cvd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  cvd_regs #(.CNT_W(CW)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .busy_i(busy),
    .ctrl_o(ctrl), .pre_cnt_o(pre_cnt), .acq_cnt_o(acq_cnt),
    .guard_o(guard_pol), .start_o(start_req), .abort_o(abort_req),
    .rd_data_o(rd_data)
  );

  cvd_timer #(.CNT_W(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n_s),
    .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  cvd_fsm #(.CNT_W(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n_s),
    .start_i(start_req), .abort_i(abort_req),
    .pre_cnt_i(pre_cnt), .acq_cnt_i(acq_cnt),
    .dbl_en_i(dbl_mode), .adc_done_i(adc_done), .tmr_zero_i(tmr_zero),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .phase_o(phase), .idx_o(second),
    .done_o(samp_done), .done_idx_o(samp_idx)
  );

  // output decode: polarity flip only for the second sample
  assign dbl_mode     = ctrl.dbl_en;
  assign flip         = dbl_mode && ctrl.inv_en && second;
  assign in_pre       = (phase == PH_PRE);
  assign busy         = (phase != PH_IDLE);
  assign adc_conv     = (phase == PH_CONV);
  assign ext_drv_en   = in_pre;
  assign ext_drv_lvl  = in_pre && (ctrl.ext_pol ^ flip);
  assign hold_drv_en  = in_pre;
  assign hold_drv_lvl = in_pre && (ctrl.int_pol ^ flip);
  assign pin_ovr_en   = in_pre && ctrl.ovr_en;
  assign pin_ovr_lvl  = pin_ovr_en && (ctrl.int_pol ^ flip);
  assign guard_lvl    = guard_pol ^ flip;
  assign pin_pass_en  = ctrl.pass_en;
  assign pin_lowz_en  = ctrl.lowz_en;
endmodule

// File: rtl/cvd_seq_chk.sv
module cvd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       busy,
  input logic       ext_drv_en,
  input logic       hold_drv_en,
  input logic       pin_ovr_en,
  input logic       adc_conv,
  input logic       adc_done,
  input logic       samp_done,
  input logic       samp_idx,
  input logic       dbl_mode
);
  p_pre_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_drv_en |-> (hold_drv_en && busy));

  p_conv_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> (!ext_drv_en && busy));

  p_ovr_in_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ovr_en |-> ext_drv_en);

  p_done_follows_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_conv && adc_done && !(wr_en && wr_addr == 2'd3)) |=> samp_done);

  p_second_needs_dbl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_done && samp_idx) |-> dbl_mode);

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr == 2'd3 && !wr_data[0]) |=>
      (!busy && !ext_drv_en && !adc_conv));
endmodule

bind cvd_seq cvd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n_s),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy), .ext_drv_en(ext_drv_en), .hold_drv_en(hold_drv_en),
  .pin_ovr_en(pin_ovr_en), .adc_conv(adc_conv), .adc_done(adc_done),
  .samp_done(samp_done), .samp_idx(samp_idx), .dbl_mode(dbl_mode)
);

// File: tb/tb_cvd_seq.sv
module tb_cvd_seq;
  logic       clk, rst_n;
  logic       wr_en, adc_done;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic adc_conv, busy, ext_drv_en, ext_drv_lvl, hold_drv_en, hold_drv_lvl;
  logic guard_lvl, pin_ovr_en, pin_ovr_lvl, pin_pass_en, pin_lowz_en;
  logic samp_done, samp_idx;
  int   n_chk, n_fail;
  logic done_flag;

  cvd_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .adc_done(adc_done), .adc_conv(adc_conv), .busy(busy),
    .ext_drv_en(ext_drv_en), .ext_drv_lvl(ext_drv_lvl),
    .hold_drv_en(hold_drv_en), .hold_drv_lvl(hold_drv_lvl),
    .guard_lvl(guard_lvl), .pin_ovr_en(pin_ovr_en), .pin_ovr_lvl(pin_ovr_lvl),
    .pin_pass_en(pin_pass_en), .pin_lowz_en(pin_lowz_en),
    .samp_done(samp_done), .samp_idx(samp_idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at falling edge, return at the falling edge after the sampling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_conv();
    adc_done = 1'b1;
    @(negedge clk);
    adc_done = 1'b0;
  endtask

  task automatic t_reset();
    rd_addr = 2'd0; #1;
    chk("R1 ctrl reg", rd_data, 8'h00);
    rd_addr = 2'd3; #1;
    chk("R1 run reg", rd_data, 8'h00);
    chk("R1 busy", busy, 0);
    chk("R1 outputs", {ext_drv_en, hold_drv_en, pin_ovr_en, pin_pass_en,
                       pin_lowz_en, adc_conv, samp_done, guard_lvl}, 8'h00);
  endtask

  task automatic t_regs();
    wr(2'd0, 8'hFF);
    rd_addr = 2'd0; #1;
    chk("R2 unused bit2 reads 0", rd_data, 8'hFB);
    wr(2'd1, 8'hA5);
    rd_addr = 2'd1; #1;
    chk("R2 pre count", rd_data, 8'hA5);
    wr(2'd2, 8'h3C);
    rd_addr = 2'd2; #1;
    chk("R2 acq count", rd_data, 8'h3C);
    wr(2'd3, 8'h02);
    chk("R11 guard level", guard_lvl, 1);
    chk("R11 stays idle", busy, 0);
    rd_addr = 2'd3; #1;
    chk("R2 run reg", rd_data, 8'h02);
    wr(2'd3, 8'h00);
    chk("R11 guard low", guard_lvl, 0);
  endtask

  task automatic t_single();
    wr(2'd0, 8'hC2);               // both polarities high, invert set, single mode
    wr(2'd1, 8'd3);
    wr(2'd2, 8'd2);
    wr(2'd3, 8'h01);
    for (int i = 0; i < 3; i++) begin
      chk("R3 pre drive", {ext_drv_en, ext_drv_lvl, hold_drv_en, hold_drv_lvl}, 4'hF);
      chk("R3 no conv in pre", adc_conv, 0);
      @(negedge clk);
    end
    for (int i = 0; i < 2; i++) begin
      chk("R4 acq phase", {ext_drv_en, hold_drv_en, adc_conv, busy}, 4'b0001);
      @(negedge clk);
    end
    for (int i = 0; i < 3; i++) begin
      chk("R4 conv held", adc_conv, 1);
      @(negedge clk);
    end
    chk("R4 conv before done", adc_conv, 1);
    finish_conv();
    chk("R5 done pulse", {samp_done, samp_idx, busy, adc_conv}, 4'b1000);
    @(negedge clk);
    chk("R5 done one cycle", samp_done, 0);
    chk("R5 invert ignored, no second", busy, 0);
  endtask

  task automatic t_double_inv();
    wr(2'd0, 8'h8B);               // channel high, hold low, override, invert, double
    wr(2'd1, 8'd2);
    wr(2'd2, 8'd1);
    wr(2'd3, 8'h03);               // go with guard high
    chk("R7 first levels", {ext_drv_lvl, hold_drv_lvl, pin_ovr_en, pin_ovr_lvl, guard_lvl}, 5'b10101);
    @(negedge clk); @(negedge clk);
    chk("R8 override off in acq", pin_ovr_en, 0);
    @(negedge clk);
    chk("R4 conv after acq", adc_conv, 1);
    finish_conv();
    chk("R6 first done", {samp_done, samp_idx, busy}, 3'b101);
    chk("R6 second pre at once", ext_drv_en, 1);
    chk("R7 inverted levels", {ext_drv_lvl, hold_drv_lvl, pin_ovr_lvl, guard_lvl}, 4'b0110);
    rd_addr = 2'd0; #1;
    chk("R7 stored bits unchanged", rd_data, 8'h8B);
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R6 second conv", adc_conv, 1);
    finish_conv();
    chk("R6 second done", {samp_done, samp_idx, busy}, 3'b110);
    chk("R7 guard restored", guard_lvl, 1);
  endtask

  task automatic t_double_plain();
    wr(2'd0, 8'h81);               // double without invert
    wr(2'd1, 8'd1);
    wr(2'd2, 8'd0);
    wr(2'd3, 8'h01);
    @(negedge clk);
    finish_conv();
    chk("R7 no invert without bit", {ext_drv_en, ext_drv_lvl, busy}, 3'b111);
    @(negedge clk);
    finish_conv();
    chk("R6 ends after two", {samp_done, samp_idx, busy}, 3'b110);
  endtask

  task automatic t_zero();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd0);
    wr(2'd2, 8'd0);
    wr(2'd3, 8'h01);
    chk("R4 zero counts skip to conv", {ext_drv_en, adc_conv, busy}, 3'b011);
    finish_conv();
    chk("R5 zero-count done", {samp_done, busy}, 2'b10);
  endtask

  task automatic t_abort();
    wr(2'd0, 8'hC8);
    wr(2'd1, 8'd5);
    wr(2'd3, 8'h01);
    @(negedge clk);
    chk("R10 running", {busy, ext_drv_en, pin_ovr_en}, 3'b111);
    wr(2'd3, 8'h00);
    chk("R10 abort idle", {busy, ext_drv_en, hold_drv_en, pin_ovr_en, adc_conv}, 5'b0);
    @(negedge clk);
    chk("R10 no done", samp_done, 0);
  endtask

  task automatic t_pins();
    wr(2'd0, 8'h10);
    chk("R9 pass only", {pin_pass_en, pin_lowz_en}, 2'b10);
    wr(2'd0, 8'h20);
    chk("R9 lowz only", {pin_pass_en, pin_lowz_en}, 2'b01);
    wr(2'd0, 8'h00);
    chk("R9 disconnected", {pin_pass_en, pin_lowz_en}, 2'b00);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done_flag = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; adc_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_single();
    t_double_inv();
    t_double_plain();
    t_zero();
    t_abort();
    t_pins();
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule